// File: doc/BRIEF.md
# Infrared Receive FIFO with Interrupt Status

This block sits between an infrared pulse sampler and a host register interface. The sampler hands it run-length bytes. The block stores them in a first-in first-out buffer whose depth is a parameter, 16 or 64 entries. The host removes one byte each time it reads the data port.

Three event flags tell the host when to act. The first reports a byte that arrived while the buffer was full. The second reports the end of a received pulse train. The third reports that the buffer holds more entries than a programmable fill level. A single status word returns these flags together with the live entry count. The host clears the two sticky flags by writing ones to them. An enable word selects which flags drive the single interrupt line, and it also carries the fill level.

Top module: `ir_rx_fifo_irq`

## Requirements
- R1: After reset the status word is zero, the interrupt line is low, all enables are zero, and the fill level reads DEPTH/2-1.
- R2: Bytes are returned in arrival order, and status bits [8 +: CNT_W] report the number of stored entries. CNT_W is $clog2(DEPTH)+1, so the field holds at most 2*DEPTH-1.
- R3: A byte that arrives while the buffer is full and no pop occurs sets status bit 0 (overflow). That byte is discarded, and the stored contents and the count are kept.
- R4: A byte delivered with the end-of-train marker sets status bit 1 (packet end) on the same clock edge that stores the byte.
- R5: Writing the status word clears each of bits 0 and 1 where the written bit is one and leaves it where the written bit is zero. Both can be cleared in one write. A flag set in the same cycle as a clear stays set.
- R6: Status bit 4 (data available) is live: it is one exactly while the count exceeds the fill level, it follows every push and pop, and writes to it have no effect.
- R7: The interrupt line is high exactly when some status bit among 0, 1 and 4 is one and its enable bit, at the same position of the enable word, is one.
- R8: A read of the data port while the buffer is empty returns zero and leaves the count at zero.
- R9: A write to the enable word loads the enables from bits 0, 1 and 4 and the fill level from bits [8 +: $clog2(DEPTH)]. The enable word reads back these fields in the same positions.
- R10: When the buffer is full, a push together with a pop in the same cycle stores the new byte, removes the oldest byte and does not set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sampler delivers a byte this cycle |
| in_byte | input | DATA_W | Run-length byte from the sampler |
| in_last | input | 1 | Delivered byte ends a pulse train |
| pop_req | input | 1 | Host reads the data port (pops one byte) |
| pop_byte | output | DATA_W | Oldest stored byte, or zero when empty |
| sts_wr | input | 1 | Write strobe for the status word (write-one-to-clear) |
| en_wr | input | 1 | Write strobe for the enable word |
| wdata | input | 32 | Write data for both words |
| sts_word | output | 32 | Flags at bits 0, 1, 4 and entry count at bit 8 upward |
| en_word | output | 32 | Enables at bits 0, 1, 4 and fill level at bit 8 upward |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=16, the small variant. At this depth every count from empty to full, and every fill level from 0 to 15, can be reached in a few hundred cycles. The bench therefore sweeps all levels against a fixed count and all eight enable combinations against several flag patterns. It covers both edges of the buffer: overflow with the dropped byte shown to be absent, a push and pop together at full, and a read while empty. It also drives a packet-end set in the same cycle as a clear of that flag.

// File: rtl/irf_pkg.sv
package irf_pkg;
   localparam int BIT_OVF = 0;
   localparam int BIT_PKT = 1;
   localparam int BIT_AVL = 4;
   localparam int CNT_LSB = 8;
   localparam int LVL_LSB = 8;

   typedef struct packed {
      logic avl;
      logic pkt;
      logic ovf;
   } irf_flags_t;
endpackage

// File: rtl/irf_store.sv
module irf_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              drop
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic              full, empty, pop_ok, accept;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign pop_ok  = pop && !empty;
   assign accept  = push && (!full || pop_ok);
   assign drop    = push && !accept;
   assign rd_data = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (accept) wptr <= wptr + 1'b1;
         if (pop_ok) rptr <= rptr + 1'b1;
         case ({accept, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R2: occupancy never passes the depth
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R8: popping an empty buffer leaves it empty
   assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count == '0));
   // R3: a dropped byte leaves the buffer full
   assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/irf_status.sv
module irf_status
   import irf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int LVL_W = $clog2(DEPTH),
   localparam int CNT_W = LVL_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_ovf,
   input  logic             set_pkt,
   input  logic [CNT_W-1:0] count,
   input  logic             sts_wr,
   input  logic             en_wr,
   input  logic [31:0]      wdata,
   output irf_flags_t       flags,
   output irf_flags_t       en,
   output logic [LVL_W-1:0] level
);
   logic ovf_q, pkt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         pkt_q <= 1'b0;
         en    <= '0;
         level <= LVL_W'(DEPTH / 2 - 1);
      end else begin
         ovf_q <= set_ovf | (ovf_q & ~(sts_wr & wdata[BIT_OVF]));
         pkt_q <= set_pkt | (pkt_q & ~(sts_wr & wdata[BIT_PKT]));
         if (en_wr) begin
            en.ovf <= wdata[BIT_OVF];
            en.pkt <= wdata[BIT_PKT];
            en.avl <= wdata[BIT_AVL];
            level  <= wdata[LVL_LSB +: LVL_W];
         end
      end
   end

   always_comb begin
      flags.ovf = ovf_q;
      flags.pkt = pkt_q;
      flags.avl = (count > {1'b0, level});
   end

   // R3: overflow event raises its flag
   assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_ovf |=> flags.ovf);
   // R4: end-of-train raises its flag at the storing edge
   assert_pkt_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_pkt |=> flags.pkt);
   // R5: a one written to bit 0 clears overflow when no new event arrives
   assert_w1c_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && wdata[BIT_OVF] && !set_ovf) |=> !flags.ovf);
   // R9: fill level follows an enable-word write
   assert_level_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (level == $past(wdata[LVL_LSB +: LVL_W])));
endmodule

// File: rtl/irf_irq.sv
module irf_irq
   import irf_pkg::*;
#(
   parameter int N_SRC = 3
) (
   input  logic [N_SRC-1:0] flags,
   input  logic [N_SRC-1:0] en,
   output logic             irq
);
   logic [N_SRC-1:0] term;

   for (genvar i = 0; i < N_SRC; i++) begin : g_term
      assign term[i] = flags[i] & en[i];
   end

   assign irq = |term;
endmodule

// File: rtl/ir_rx_fifo_irq.sv
module ir_rx_fifo_irq
   import irf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              in_last,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_byte,
   input  logic              sts_wr,
   input  logic              en_wr,
   input  logic [31:0]       wdata,
   output logic [31:0]       sts_word,
   output logic [31:0]       en_word,
   output logic              irq
);
   localparam int LVL_W = $clog2(DEPTH);
   localparam int CNT_W = LVL_W + 1;

   if (!(DEPTH == 16 || DEPTH == 64)) begin : g_bad_depth
      $error("ir_rx_fifo_irq: DEPTH must be 16 or 64");
   end
   if (DATA_W < 1 || CNT_LSB + CNT_W > 32) begin : g_bad_width
      $error("ir_rx_fifo_irq: field widths out of range");
   end

   logic [CNT_W-1:0] count;
   logic             drop;
   irf_flags_t       flags, en;
   logic [LVL_W-1:0] level;

   irf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_valid),
      .push_data (in_byte),
      .pop       (pop_req),
      .rd_data   (pop_byte),
      .count     (count),
      .drop      (drop)
   );

   irf_status #(.DEPTH(DEPTH)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ovf (drop),
      .set_pkt (in_valid && in_last),
      .count   (count),
      .sts_wr  (sts_wr),
      .en_wr   (en_wr),
      .wdata   (wdata),
      .flags   (flags),
      .en      (en),
      .level   (level)
   );

   irf_irq #(.N_SRC(3)) u_irq (
      .flags (flags),
      .en    (en),
      .irq   (irq)
   );

   always_comb begin
      sts_word                     = '0;
      sts_word[BIT_OVF]            = flags.ovf;
      sts_word[BIT_PKT]            = flags.pkt;
      sts_word[BIT_AVL]            = flags.avl;
      sts_word[CNT_LSB +: CNT_W]   = count;
      en_word                      = '0;
      en_word[BIT_OVF]             = en.ovf;
      en_word[BIT_PKT]             = en.pkt;
      en_word[BIT_AVL]             = en.avl;
      en_word[LVL_LSB +: LVL_W]    = level;
   end

   // R7: no enabled flag means a quiet interrupt line one cycle on
   assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_word[BIT_OVF]) == 1'b0 && $past(en_word[BIT_PKT]) == 1'b0 &&
       $past(en_word[BIT_AVL]) == 1'b0 && !en_wr && $stable(en_word)) |-> !irq);
endmodule

// File: tb/tb_ir_rx_fifo_irq.sv
module tb_ir_rx_fifo_irq;
   localparam int DEPTH = 16;
   localparam int DW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_last = 1'b0, pop_req = 1'b0;
   logic [DW-1:0] in_byte = '0;
   logic [DW-1:0] pop_byte;
   logic          sts_wr = 1'b0, en_wr = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   sts_word, en_word;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   ir_rx_fifo_irq #(.DEPTH(DEPTH), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .pop_req(pop_req), .pop_byte(pop_byte),
      .sts_wr(sts_wr), .en_wr(en_wr), .wdata(wdata),
      .sts_word(sts_word), .en_word(en_word), .irq(irq)
   );

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   function automatic int cnt_f();
      return int'(sts_word[12:8]);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, input logic last);
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_last = last;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic pop(output logic [7:0] b);
      @(negedge clk);
      pop_req = 1'b1;
      #1 b = pop_byte;
      @(negedge clk);
      pop_req = 1'b0;
   endtask

   task automatic wr_sts(input logic [31:0] v);
      @(negedge clk);
      sts_wr = 1'b1; wdata = v;
      @(negedge clk);
      sts_wr = 1'b0;
   endtask

   task automatic wr_en(input logic [31:0] v);
      @(negedge clk);
      en_wr = 1'b1; wdata = v;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   function automatic int irq_exp(input logic [31:0] e);
      return int'((sts_word[0] & e[0]) | (sts_word[1] & e[1]) | (sts_word[4] & e[4]));
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", int'(sts_word), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 enable word", int'(en_word), (DEPTH / 2 - 1) << 8);

      // R9 enable all three sources, level 7
      wr_en(32'h0000_0713);
      chk("R9 readback", int'(en_word), 32'h0713);

      // R2/R6/R7 fill sweep
      for (int i = 0; i < DEPTH; i++) begin
         push(pat(i), 1'b0);
         chk("R2 count", cnt_f(), i + 1);
         chk("R6 avail", int'(sts_word[4]), int'(i + 1 > 7));
         chk("R7 irq", int'(irq), int'(i + 1 > 7));
      end

      // R3 overflow: push while full
      push(8'd99, 1'b0);
      chk("R3 ovf bit", int'(sts_word[0]), 1);
      chk("R3 count kept", cnt_f(), DEPTH);

      // R5 zeros leave flags, ones clear; R6 avail not writable
      wr_sts(32'h0);
      chk("R5 zero write keeps", int'(sts_word[0]), 1);
      wr_sts(32'h13);
      chk("R5 one clears", int'(sts_word[0]), 0);
      chk("R6 avail write ignored", int'(sts_word[4]), 1);

      // R10 push and pop together while full
      @(negedge clk);
      in_valid = 1'b1; in_byte = 8'hEE; pop_req = 1'b1;
      #1 b = pop_byte;
      @(negedge clk);
      in_valid = 1'b0; pop_req = 1'b0;
      chk("R10 oldest out", int'(b), int'(pat(0)));
      chk("R10 count", cnt_f(), DEPTH);
      chk("R10 no ovf", int'(sts_word[0]), 0);

      // R2 drain in order, R6 avail follows pops, R3 dropped byte absent
      for (int i = 1; i <= DEPTH; i++) begin
         pop(b);
         chk("R2 order", int'(b), (i < DEPTH) ? int'(pat(i)) : 32'hEE);
         chk("R2 count down", cnt_f(), DEPTH - i);
         chk("R6 avail after pop", int'(sts_word[4]), int'(DEPTH - i > 7));
      end

      // R8 empty read
      pop(b);
      chk("R8 empty data", int'(b), 0);
      chk("R8 empty count", cnt_f(), 0);

      // R4 packet end with its byte
      push(8'h42, 1'b1);
      chk("R4 pkt bit", int'(sts_word[1]), 1);
      chk("R4 count same edge", cnt_f(), 1);
      push(8'h43, 1'b0);
      push(8'h44, 1'b0);
      for (int k = 0; k < DEPTH - 3; k++) push(8'(k), 1'b0);
      push(8'h55, 1'b0);
      chk("R3 ovf again", int'(sts_word[0]), 1);

      // R5 clear both in one write
      wr_sts(32'h3);
      chk("R5 clear both", int'(sts_word[1:0]), 0);

      // R5 set wins over clear in same cycle (buffer full: drop sets ovf too)
      @(negedge clk);
      in_valid = 1'b1; in_last = 1'b1; in_byte = 8'h66;
      sts_wr = 1'b1; wdata = 32'h3;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; sts_wr = 1'b0;
      chk("R5 pkt set wins", int'(sts_word[1]), 1);
      chk("R5 ovf set wins", int'(sts_word[0]), 1);

      // drain to 8 entries
      for (int k = 0; k < DEPTH - 8; k++) pop(b);
      chk("R2 count 8", cnt_f(), 8);

      // R6/R9 level sweep against count 8
      for (int lv = 0; lv < DEPTH; lv++) begin
         wr_en(32'(lv) << 8);
         chk("R9 level readback", int'(en_word[11:8]), lv);
         chk("R6 avail vs level", int'(sts_word[4]), int'(8 > lv));
      end

      // R7 enable sweep under two flag patterns
      for (int pass = 0; pass < 2; pass++) begin
         if (pass == 1) wr_sts(32'h1);
         for (int e = 0; e < 8; e++) begin
            logic [31:0] ew;
            ew = {16'h0, 4'h0, 4'(pass == 0 ? 0 : 15), 3'b0, 1'(e >> 2), 2'b0, 2'(e)};
            wr_en(ew);
            chk("R7 irq sweep", int'(irq), irq_exp(ew));
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule